// File: doc/BRIEF.md
# Cache Line Refill Bus Sequencer

This block runs one cache-line load over a memory bus that is shared between address and data. Only the low half of each memory clock carries these transfers. When a miss request arrives, the sequencer latches the miss address and places it on the bus for exactly one clock. It then captures eight half-instruction beats. For each of the four instructions the low half comes first and the high half second. After the last beat it gives the bus back to ordinary function-source traffic.

For the whole load the sequencer holds a miss status line high and drives active-low row and column strobes toward local memory. The row strobe opens before the column strobe and closes after it. Each instruction is joined as high half above low half and is handed to the cache, with its word index, one clock after its high half is captured. A line-done pulse then closes the load. The memory array and the cache storage are outside the block.

The state machine has four states, each named with its transitions:

- `ST_IDLE`: moves to `ST_ADDR` when `miss_req` is high. Otherwise it stays in `ST_IDLE`.
- `ST_ADDR`: always moves to `ST_DATA`, with the beat counter cleared.
- `ST_DATA`: stays in `ST_DATA` while the beat count is below 7. It moves to `ST_DONE` after beat 7.
- `ST_DONE`: always moves to `ST_IDLE`.

Top module: `line_refill_seq`

## Requirements
- R1: After reset the block is idle. `miss` is 0, `ras_n` and `cas_n` are 1, `fs_sel` is 1, `addr_oe` is 0, and `wr_en` and `line_done` are 0.
- R2: In the clock after `miss_req` is sampled high in idle, `addr_oe` is 1 and `bus_addr` equals the `miss_addr` sampled with the request. `addr_oe` is 1 in that clock only, and `bus_addr` is 0 whenever `addr_oe` is 0.
- R3: The eight clocks after the address clock are data beats 0..7. In beat k, `bus_in` is captured as half 2j+0 (low) or 2j+1 (high) of word j = k/2, so the order is I0L, I0H, I1L, I1H, I2L, I2H, I3L, I3H.
- R4: One clock after beat 2j+1, `wr_en` is 1 for one clock, `wr_idx` is j, and `wr_data` is {high half, low half}, with the high half in bits [31:16]. At all other times `wr_en` is 0.
- R5: `line_done` is 1 for exactly the one clock after beat 7. In that clock the write of word 3 is also presented.
- R6: `miss` is 1 from the address clock through the line-done clock, and 0 in the clock after it.
- R7: `ras_n` is 0 from the address clock through the line-done clock. `cas_n` is 0 only during the eight data beats, so `cas_n` low always implies `ras_n` low.
- R8: `fs_sel` is 0 during the address clock and the data beats. It is 1 in idle and in the line-done clock, when the bus is back in function-source use.
- R9: A `miss_req` seen in any state other than idle is ignored. A request held high through a whole load, and dropped in the line-done clock, starts no second load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_req | input | 1 | Cache miss request |
| miss_addr | input | 32 | Program counter of the missing line |
| bus_in | input | 16 | Half-instruction read from the shared bus |
| addr_oe | output | 1 | Sequencer drives the address onto the bus |
| bus_addr | output | 32 | Address driven in the address clock |
| fs_sel | output | 1 | Bus low half free for function-source use |
| miss | output | 1 | Load in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| wr_en | output | 1 | Instruction write to the cache |
| wr_idx | output | 2 | Word index of the written instruction |
| wr_data | output | 32 | Assembled instruction |
| line_done | output | 1 | One-clock pulse ending the load |

## Verification
The last instruction write and the line-done pulse fall in the same clock. That same clock is also where a still-pending miss request must be ignored. The bench holds `miss_req` high through every second load and releases it only in that final clock. In that clock it checks `wr_idx` 3, the word 3 data and `line_done` together. In the next clock it requires `miss`, `addr_oe` and the strobes to be back at rest.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } lrs_state_e;
endpackage

// File: rtl/lrs_fsm.sv
module lrs_fsm #(
    parameter int BEATS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      miss_req,
    output logic                      accept,
    output logic                      in_data,
    output logic [$clog2(BEATS)-1:0]  beat,
    output logic                      addr_oe,
    output logic                      fs_sel,
    output logic                      miss,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      line_done
);
    import lrs_pkg::*;
    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    lrs_state_e state_q, state_d;
    logic [BW-1:0] beat_q, beat_d;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: if (miss_req) state_d = ST_ADDR;
            ST_ADDR: begin
                state_d = ST_DATA;
                beat_d  = '0;
            end
            ST_DATA: begin
                if (beat_q == LAST) state_d = ST_DONE;
                else                beat_d  = beat_q + 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        accept    = 1'b0;
        in_data   = 1'b0;
        addr_oe   = 1'b0;
        fs_sel    = 1'b1;
        miss      = 1'b0;
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        line_done = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = miss_req;
            ST_ADDR: begin
                addr_oe = 1'b1;
                fs_sel  = 1'b0;
                miss    = 1'b1;
                ras_n   = 1'b0;
            end
            ST_DATA: begin
                in_data = 1'b1;
                fs_sel  = 1'b0;
                miss    = 1'b1;
                ras_n   = 1'b0;
                cas_n   = 1'b0;
            end
            ST_DONE: begin
                miss      = 1'b1;
                ras_n     = 1'b0;
                line_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign beat = beat_q;

    // R7
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    // R2
    addr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |=> (!addr_oe && !cas_n));
    // R6
    miss_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !miss);
    // R8
    bus_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !fs_sel);
endmodule

// File: rtl/lrs_assemble.sv
module lrs_assemble #(
    parameter int HW    = 16,
    parameter int WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_data,
    input  logic [$clog2(2*WORDS)-1:0]    beat,
    input  logic [HW-1:0]                 bus_in,
    output logic                          wr_en,
    output logic [$clog2(WORDS)-1:0]      wr_idx,
    output logic [2*HW-1:0]               wr_data
);
    localparam int IW = $clog2(WORDS);
    localparam int BW = IW + 1;

    logic [HW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q   <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (in_data) begin
                if (!beat[0]) begin
                    low_q <= bus_in;
                end else begin
                    wr_en   <= 1'b1;
                    wr_idx  <= beat[BW-1:1];
                    wr_data <= {bus_in, low_q};
                end
            end
        end
    end

    // R4
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
    parameter int AW    = 32,
    parameter int HW    = 16,
    parameter int WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      miss_req,
    input  logic [AW-1:0]             miss_addr,
    input  logic [HW-1:0]             bus_in,
    output logic                      addr_oe,
    output logic [AW-1:0]             bus_addr,
    output logic                      fs_sel,
    output logic                      miss,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      wr_en,
    output logic [$clog2(WORDS)-1:0]  wr_idx,
    output logic [2*HW-1:0]           wr_data,
    output logic                      line_done
);
    localparam int BEATS = 2 * WORDS;
    localparam int BW    = $clog2(BEATS);

    logic          accept;
    logic          in_data;
    logic [BW-1:0] beat;
    logic [AW-1:0] addr_q;

    lrs_fsm #(.BEATS(BEATS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req),
        .accept(accept), .in_data(in_data), .beat(beat),
        .addr_oe(addr_oe), .fs_sel(fs_sel), .miss(miss),
        .ras_n(ras_n), .cas_n(cas_n), .line_done(line_done)
    );

    lrs_assemble #(.HW(HW), .WORDS(WORDS)) u_asm (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .beat(beat),
        .bus_in(bus_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= miss_addr;
    end

    assign bus_addr = addr_oe ? addr_q : '0;

    // R5
    done_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (wr_en && (wr_idx == $clog2(WORDS)'(WORDS - 1))));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && miss_req) |=> !addr_oe);
endmodule

// File: tb/sim_line_refill_seq.sv
`timescale 1ns/1ps
module sim_line_refill_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_req = 1'b0;
    logic [31:0] miss_addr = '0;
    logic [15:0] bus_in = '0;
    logic        addr_oe, fs_sel, miss, ras_n, cas_n, wr_en, line_done;
    logic [31:0] bus_addr, wr_data;
    logic [1:0]  wr_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    line_refill_seq u0 (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
        .bus_in(bus_in), .addr_oe(addr_oe), .bus_addr(bus_addr), .fs_sel(fs_sel),
        .miss(miss), .ras_n(ras_n), .cas_n(cas_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .line_done(line_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] half(input int seed, input int k);
        return 16'((seed * 40503 + k * 4369 + k + 7) & 16'hFFFF);
    endfunction

    task automatic run_load(input int seed, input logic [31:0] addr, input bit hold);
        @(negedge clk);
        miss_req  = 1'b1;
        miss_addr = addr;
        @(negedge clk);
        if (!hold) miss_req = 1'b0;
        miss_addr = ~addr;
        chk(addr_oe == 1'b1, "R2 addr_oe", addr_oe, 1);
        chk(bus_addr == addr, "R2 bus_addr", bus_addr, addr);
        chk(miss && !ras_n && cas_n, "R6/R7 addr clock strobes", {miss, ras_n, cas_n}, 3'b101);
        chk(fs_sel == 1'b0, "R8 fs_sel addr", fs_sel, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            bus_in = half(seed, k);
            chk(!cas_n && !ras_n && miss && !fs_sel && !addr_oe, "R3/R7 data beat",
                {cas_n, ras_n, miss, fs_sel, addr_oe}, 5'b00100);
            chk(bus_addr == 32'h0, "R2 bus_addr idle", bus_addr, 0);
            if (k >= 2 && k % 2 == 0) begin
                chk(wr_en && wr_idx == 2'(k / 2 - 1), "R4 write idx", {wr_en, wr_idx}, {1'b1, 2'(k / 2 - 1)});
                chk(wr_data == {half(seed, k - 1), half(seed, k - 2)}, "R4 write data",
                    wr_data, {half(seed, k - 1), half(seed, k - 2)});
            end else begin
                chk(!wr_en, "R4 no write", wr_en, 0);
            end
            chk(!line_done, "R5 no early done", line_done, 0);
        end
        @(negedge clk);
        bus_in = 16'hDEAD;
        chk(line_done == 1'b1, "R5 line_done", line_done, 1);
        chk(wr_en && wr_idx == 2'd3, "R5 last write", {wr_en, wr_idx}, 3'b111);
        chk(wr_data == {half(seed, 7), half(seed, 6)}, "R4 last data",
            wr_data, {half(seed, 7), half(seed, 6)});
        chk(miss && !ras_n && cas_n && fs_sel, "R7/R8 done clock",
            {miss, ras_n, cas_n, fs_sel}, 4'b1011);
        miss_req = 1'b0;
        @(negedge clk);
        chk(!miss && ras_n && cas_n && !addr_oe, "R6/R9 after load",
            {miss, ras_n, cas_n, addr_oe}, 4'b0110);
        chk(!line_done && !wr_en, "R5 single pulse", {line_done, wr_en}, 0);
    endtask

    initial begin
        #1;
        chk(!miss && ras_n && cas_n && fs_sel && !addr_oe && !wr_en && !line_done,
            "R1 reset state", {miss, ras_n, cas_n, fs_sel, addr_oe, wr_en, line_done}, 7'b0111000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!miss && ras_n && cas_n && fs_sel, "R1 after release", {miss, ras_n, cas_n, fs_sel}, 4'b0111);
        for (int s = 0; s < 48; s++)
            run_load(s, 32'h1000_0000 + 32'(s * 16) ^ 32'(s << 20), s % 2 == 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule